// File: doc/BRIEF.md
# CAN Bus Wake-Up Pattern Detector

This block watches the receive level of a CAN bus while the transceiver sits in a low-power state. It reports a remote wake-up only when it sees a complete recessive, dominant, recessive, dominant pattern in which every phase lasts long enough. The whole pattern must also finish inside a programmable window. Short spikes that fall between the qualified phases do not break a pattern that has already started. The bus bit is first passed through a two-flop synchronizer. All phase timing is done in clock cycles, against thresholds that arrive on input ports.

A decoder turns the system mode field, the standby-control bit and a supply-good input into a transceiver state: active, low-power or off. Detection runs only in the low-power state. Leaving that state drops any partial pattern. A wake produces a one-cycle pulse and also sets a sticky flag, which is cleared by a dedicated input.

Top module: `canwk_detect`

## Requirements
- R1: `xcvr_state_o` is 2'b01 (low-power) whenever `stby_ctl_i` is 1. It is 2'b10 (active) when `mode_ctl_i[1]` is 1, `stby_ctl_i` is 0 and `supply_ok_i` is 1. In every other case it is 2'b00 (off). Mode values 00 and 01 are the low-power system states, and 10 and 11 are normal operation.
- R2: A wake can occur only while the state is low-power. Any other state, even for a single cycle, discards a partially seen pattern.
- R3: A qualified recessive phase, then a qualified dominant phase, then a qualified recessive phase, then a qualified dominant phase, in that order, produce exactly one wake.
- R4: A recessive phase qualifies after `min_rec_i` consecutive synchronized recessive samples (bus bit 1). A dominant phase qualifies after `min_dom_i` consecutive synchronized dominant samples (bus bit 0). Shorter runs advance nothing.
- R5: A window timer starts at the first dominant sample after the first recessive phase has qualified. If the timer reaches `timeout_i` before the final dominant phase qualifies, the pattern restarts from idle. A recessive level that is still present may then qualify again as a new first phase.
- R6: Runs shorter than the thresholds, of either level, that occur between qualified phases do not cancel the pattern in progress.
- R7: `wake_pulse_o` is high for exactly one cycle per wake.
- R8: `wake_flag_o` is set by a wake and stays set until `wake_clr_i` is sampled high. A clear in the same cycle as a wake leaves the flag set.
- R9: `wake_pulse_o` rises `min_dom_i`+2 clock edges after the final dominant level first appears on `bus_rx_i`. This is two synchronizer stages plus the qualifying run plus the output register.
- R10: During and right after reset, `wake_pulse_o` and `wake_flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rx_i | input | 1 | Bus receive level, 1 recessive, 0 dominant |
| mode_ctl_i | input | 2 | System mode field |
| stby_ctl_i | input | 1 | Standby control of the transceiver |
| supply_ok_i | input | 1 | Transceiver supply is above its threshold |
| min_rec_i | input | CNT_W | Minimum recessive phase length in cycles |
| min_dom_i | input | CNT_W | Minimum dominant phase length in cycles |
| timeout_i | input | TMO_W | Pattern window length in cycles |
| wake_clr_i | input | 1 | Clears the sticky wake flag |
| wake_pulse_o | output | 1 | One-cycle wake event |
| wake_flag_o | output | 1 | Sticky wake flag |
| xcvr_state_o | output | 2 | Transceiver state (00 off, 01 low-power, 10 active) |

## Verification
The transceiver state follows the control inputs with no register in the path, so it is checked in the same cycle the inputs are applied. The wake pulse and the flag are registered. They change on the edge on which the final dominant run reaches its threshold, which is `min_dom_i`+2 edges after that level is driven on the pin. A behavioural model in the bench steps once per rising edge, using the inputs that were present at that edge. The bench compares all three outputs at every falling edge, after the register has updated and before new stimulus is applied. The cycle of the wake pulse is also checked against the fixed `min_dom_i`+2 edge count.

// File: rtl/canwk_pkg.sv
package canwk_pkg;

  typedef enum logic [1:0] {
    XS_OFF    = 2'b00,
    XS_LOWPWR = 2'b01,
    XS_ACTIVE = 2'b10
  } xcvr_state_e;

  // Pattern progress: the stage names which phase was qualified last.
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REC1 = 2'd1,
    SQ_DOM1 = 2'd2,
    SQ_REC2 = 2'd3
  } seq_stage_e;

  // Mode field bit 1 set means normal operation.
  function automatic xcvr_state_e decode_xcvr(input logic [1:0] mode,
                                              input logic       stby,
                                              input logic       sup_ok);
    if (stby)                 return XS_LOWPWR;
    if (mode[1] && sup_ok)    return XS_ACTIVE;
    return XS_OFF;
  endfunction

endpackage

// File: rtl/canwk_sync.sv
module canwk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/canwk_runlen.sv
module canwk_runlen #(
  parameter int   CNT_W = 12,
  parameter logic LEVEL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bus_i,
  input  logic [CNT_W-1:0] min_i,
  output logic             ok_o
);
  logic [CNT_W-1:0] run_q, run_n;
  logic             at_level;

  // Saturating step: stops at the threshold instead of wrapping.
  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] lim);
    return (cur >= lim) ? lim : cur + 1'b1;
  endfunction

  assign at_level = (bus_i == LEVEL);
  assign run_n    = at_level ? sat_step(run_q, min_i) : '0;
  assign ok_o     = en_i && at_level && (run_n == min_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= '0;
    else if (en_i)  run_q <= run_n;
    else            run_q <= '0;
  end

  // R4: a threshold above one cannot be met without the level on the previous sample
  p_run_needs_history_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && min_i > 1) |-> ($past(bus_i) == LEVEL && $past(en_i)));
endmodule

// File: rtl/canwk_seq.sv
module canwk_seq
  import canwk_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bus_i,
  input  logic             rec_ok_i,
  input  logic             dom_ok_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             wake_o
);
  seq_stage_e       stage_q, stage_n;
  logic [TMO_W-1:0] tmr_q, tmr_n;
  logic             expire, tmr_run, wake_hit;

  function automatic logic [TMO_W-1:0] tmr_step(input logic [TMO_W-1:0] cur);
    return (&cur) ? cur : cur + 1'b1;
  endfunction

  assign expire  = (stage_q != SQ_IDLE) && (tmr_q >= timeout_i);
  // The window opens at the first dominant sample after phase one.
  assign tmr_run = (tmr_q != '0) || !bus_i;

  always_comb begin
    stage_n  = stage_q;
    wake_hit = 1'b0;
    if (!en_i) begin
      stage_n = SQ_IDLE;
    end else if (stage_q == SQ_IDLE) begin
      if (rec_ok_i) stage_n = SQ_REC1;
    end else if (expire) begin
      stage_n = SQ_IDLE;
    end else begin
      unique case (stage_q)
        SQ_REC1: if (dom_ok_i) stage_n = SQ_DOM1;
        SQ_DOM1: if (rec_ok_i) stage_n = SQ_REC2;
        SQ_REC2: if (dom_ok_i) begin
          stage_n  = SQ_IDLE;
          wake_hit = 1'b1;
        end
        default: stage_n = SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    if (stage_n == SQ_IDLE) tmr_n = '0;
    else if (tmr_run)       tmr_n = tmr_step(tmr_q);
    else                    tmr_n = tmr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= SQ_IDLE;
      tmr_q   <= '0;
    end else begin
      stage_q <= stage_n;
      tmr_q   <= tmr_n;
    end
  end

  assign wake_o = wake_hit;

  // R5: an expired window always sends the pattern back to idle
  p_expire_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (stage_q == SQ_IDLE));
  // R5: the idle stage never carries a running window
  p_idle_tmr_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == SQ_IDLE) |-> (tmr_q == '0));
  // R2: detection disabled leaves no progress behind
  p_disabled_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (stage_q == SQ_IDLE));
endmodule

// File: rtl/canwk_detect.sv
module canwk_detect
  import canwk_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rx_i,
  input  logic [1:0]       mode_ctl_i,
  input  logic             stby_ctl_i,
  input  logic             supply_ok_i,
  input  logic [CNT_W-1:0] min_rec_i,
  input  logic [CNT_W-1:0] min_dom_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             wake_clr_i,
  output logic             wake_pulse_o,
  output logic             wake_flag_o,
  output logic [1:0]       xcvr_state_o
);
  localparam int SYNC_STAGES = 2;
  localparam int N_LEVELS    = 2;   // index 0 dominant, index 1 recessive

  xcvr_state_e         xs;
  logic                det_en;
  logic                bus_s;
  logic [N_LEVELS-1:0] lvl_ok;
  logic                wake_hit;
  logic                pulse_q, flag_q;

  assign xs           = decode_xcvr(mode_ctl_i, stby_ctl_i, supply_ok_i);
  assign xcvr_state_o = xs;
  assign det_en       = (xs == XS_LOWPWR);

  canwk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bus_rx_i),
    .q_o    (bus_s)
  );

  generate
    for (genvar g = 0; g < N_LEVELS; g++) begin : g_run
      canwk_runlen #(.CNT_W(CNT_W), .LEVEL(1'(g))) u_run (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (det_en),
        .bus_i  (bus_s),
        .min_i  ((g == 1) ? min_rec_i : min_dom_i),
        .ok_o   (lvl_ok[g])
      );
    end
  endgenerate

  canwk_seq #(.TMO_W(TMO_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (det_en),
    .bus_i     (bus_s),
    .rec_ok_i  (lvl_ok[1]),
    .dom_ok_i  (lvl_ok[0]),
    .timeout_i (timeout_i),
    .wake_o    (wake_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= wake_hit;
      if (wake_hit)        flag_q <= 1'b1;
      else if (wake_clr_i) flag_q <= 1'b0;
    end
  end

  assign wake_pulse_o = pulse_q;
  assign wake_flag_o  = flag_q;

  // R7: never two pulse cycles back to back
  p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |=> !wake_pulse_o);
  // R8: a pulse is always accompanied by the flag
  p_flag_with_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> wake_flag_o);
  // R8: without a clear the flag holds
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_flag_o && !wake_clr_i) |=> wake_flag_o);
  // R2: outside low-power no wake may follow
  p_no_wake_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en |=> !wake_pulse_o);
  // R1: state code is one of the three legal values
  p_state_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(xcvr_state_o));
endmodule

// File: tb/canwk_detect_tb.sv
`timescale 1ns/1ps
module canwk_detect_tb;
  localparam int CNT_W = 12;
  localparam int TMO_W = 16;
  localparam int MINR  = 4;
  localparam int MIND  = 3;
  localparam int TMO   = 60;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus = 1'b1;
  logic [1:0] mode = 2'b00;
  logic stby = 1'b1;
  logic sup = 1'b1;
  logic clr = 1'b0;
  logic pulse, flag;
  logic [1:0] xst;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, np = 0, last_pulse = -1;
  logic flag_at_pulse;

  // reference model state
  bit q_sync[$] = '{1'b1, 1'b1};
  int m_rl, m_dl, m_ph, m_tmr;
  bit m_pulse, m_flag;

  always #4 clk = ~clk;

  canwk_detect #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rx_i(bus), .mode_ctl_i(mode),
    .stby_ctl_i(stby), .supply_ok_i(sup),
    .min_rec_i(CNT_W'(MINR)), .min_dom_i(CNT_W'(MIND)), .timeout_i(TMO_W'(TMO)),
    .wake_clr_i(clr), .wake_pulse_o(pulse), .wake_flag_o(flag), .xcvr_state_o(xst)
  );

  function automatic int exp_state();
    if (stby == 1'b1) return 1;
    if (mode >= 2 && sup) return 2;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic model_edge();
    bit bs;
    bit rok, dok, en;
    bs = q_sync[0];
    if (!rst_ni) begin
      m_rl = 0; m_dl = 0; m_ph = 0; m_tmr = 0; m_pulse = 0; m_flag = 0;
      q_sync = '{1'b1, 1'b1};
      return;
    end
    en = (exp_state() == 1);
    m_pulse = 0;
    if (!en) begin
      m_rl = 0; m_dl = 0; m_ph = 0; m_tmr = 0;
    end else begin
      m_rl = bs ? m_rl + 1 : 0;
      m_dl = bs ? 0 : m_dl + 1;
      rok = bs && (m_rl >= MINR);
      dok = !bs && (m_dl >= MIND);
      if (m_ph == 0) begin
        if (rok) m_ph = 1;
      end else if (m_tmr >= TMO) m_ph = 0;
      else if (m_ph == 1 && dok) m_ph = 2;
      else if (m_ph == 2 && rok) m_ph = 3;
      else if (m_ph == 3 && dok) begin m_ph = 0; m_pulse = 1; end
      if (m_ph == 0) m_tmr = 0;
      else if (m_tmr != 0 || !bs) m_tmr++;
    end
    if (m_pulse) m_flag = 1;
    else if (clr) m_flag = 0;
    void'(q_sync.pop_front());
    q_sync.push_back(bus);
  endtask

  task automatic step();
    @(negedge clk);
    model_edge();
    cyc++;
    chk(int'(xst) == exp_state(), "R1 state", xst, exp_state());
    chk(pulse == m_pulse, "R3 wake pulse", pulse, m_pulse);
    chk(flag == m_flag, "R8 wake flag", flag, m_flag);
    if (pulse) begin
      np++; last_pulse = cyc; flag_at_pulse = flag;
    end
  endtask

  task automatic hold(input bit lvl, input int n);
    bus = lvl;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic quiet();
    mode = 2'b10; stby = 1'b0; sup = 1'b1; bus = 1'b1;
    for (int i = 0; i < 4; i++) step();
    mode = 2'b00; stby = 1'b1;
    step();
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cs;
    for (int i = 0; i < 3; i++) step();
    chk(pulse == 0 && flag == 0, "R10 reset outputs", {pulse, flag}, 0);
    rst_ni = 1'b1;
    step();
    chk(pulse == 0 && flag == 0, "R10 after release", {pulse, flag}, 0);

    // R3 / R7 / R9 plain pattern
    np = 0;
    hold(1, 10); hold(0, 5); hold(1, 6);
    cs = cyc;
    hold(0, 5); hold(1, 10);
    chk(np == 1, "R3 one wake / R7 one cycle", np, 1);
    chk(last_pulse == cs + MIND + 2, "R9 pulse latency", last_pulse - cs, MIND + 2);

    quiet();
    chk(flag == 1, "R8 flag sticky", flag, 1);
    clr = 1'b1; step(); clr = 1'b0; step();
    chk(flag == 0, "R8 flag cleared", flag, 0);

    // R4 short phases never qualify
    np = 0;
    hold(1, 10); hold(0, 2); hold(1, 3); hold(0, 2); hold(1, 3); hold(0, 2); hold(1, 10);
    chk(np == 0, "R4 short phases", np, 0);
    quiet();

    // R6 glitches between qualified phases
    np = 0;
    hold(1, 10); hold(0, 5); hold(1, 1); hold(0, 4); hold(1, 6);
    hold(0, 1); hold(1, 3); hold(0, 5); hold(1, 5);
    chk(np == 1, "R6 glitch tolerant", np, 1);
    quiet();

    // R5 timeout then restart from still-recessive bus
    np = 0;
    hold(1, 10); hold(0, 5); hold(1, 70); hold(0, 5); hold(1, 10);
    chk(np == 0, "R5 expired window", np, 0);
    hold(0, 5); hold(1, 5);
    chk(np == 1, "R5 restart completes", np, 1);
    quiet();

    // R2 / R1 off and active states block detection
    np = 0;
    mode = 2'b01; stby = 1'b0;
    hold(1, 10); hold(0, 5); hold(1, 6); hold(0, 5); hold(1, 6);
    chk(xst == 2'b00, "R1 off code", xst, 0);
    mode = 2'b11; stby = 1'b0; sup = 1'b1;
    hold(1, 10); hold(0, 5); hold(1, 6); hold(0, 5); hold(1, 6);
    chk(xst == 2'b10, "R1 active code", xst, 2);
    sup = 1'b0; step();
    chk(xst == 2'b00, "R1 supply low is off", xst, 0);
    chk(np == 0, "R2 no wake when not low-power", np, 0);
    sup = 1'b1; mode = 2'b11; stby = 1'b1;
    hold(1, 10); hold(0, 5); hold(1, 6); hold(0, 5); hold(1, 6);
    chk(np == 1, "R2 normal mode with standby detects", np, 1);
    quiet();

    // R2 abort on leaving low-power mid-pattern
    np = 0;
    hold(1, 10); hold(0, 5); hold(1, 6);
    stby = 1'b0; step(); step(); stby = 1'b1;
    hold(0, 5); hold(1, 10);
    chk(np == 0, "R2 partial pattern dropped", np, 0);
    quiet();

    // R8 clear held across the wake cycle
    np = 0;
    clr = 1'b1;
    hold(1, 10); hold(0, 5); hold(1, 6); hold(0, 5);
    chk(np == 1 && flag_at_pulse == 1, "R8 wake beats clear", flag_at_pulse, 1);
    step();
    chk(flag == 0, "R8 clear after wake", flag, 0);
    clr = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule